// File: doc/BRIEF.md
# Byte-Lane Control Register File

This block holds a 64-byte space of control registers behind a host port. The port takes both 16-bit and 8-bit writes. A 16-bit word is big-endian: the even byte is the high half. Each byte has a fixed writable mask. Bits outside the mask are never stored, so they read back as zero. Reserved bytes hold nothing at all. Reads are combinational, and a read always returns the aligned word `{even byte, odd byte}`.

Four offsets are data ports rather than storage.

- **8-bit host:** a byte written to the even half of a port is held in a per-port latch. The next write to the odd half sends `{held byte, new byte}` downstream as one word and empties the latch.
- **16-bit host:** a word write to a port sends the word downstream at once.

Side effects come out as one-cycle strobes:

- a reset pulse for attached processors;
- a bank-change strobe;
- an interrupt-control update strobe.

A bank of eight mailbox words carries a dirty flag per word. A write that actually changes a mailbox word sets that word's flag. A write that leaves the word unchanged is dropped. The consumer clears each flag with its own acknowledge bit.

Top module: `ctl_regfile`

## Requirements
- R1: The address is 6 bits wide. Every access works on the aligned word at `{addr[5:1],0}`. A 16-bit write puts `wr_data[15:8]` in the even byte and `wr_data[7:0]` in the odd byte, whatever `addr[0]` is. An 8-bit write uses `wr_data[7:0]` and touches only the addressed byte. `rd_data` combinationally returns `{even byte, odd byte}` of the word at `{rd_addr[5:1],0}`.
- R2: Writable masks per byte (all other non-mailbox storage bytes keep 0xFF):

  | Byte | Mask |
  |------|------|
  | 0x00 | 0x80 |
  | 0x01 | 0x03 |
  | 0x03 | 0x03 |
  | 0x05 | 0x03 |
  | 0x07 | 0x07 |
  | 0x0B | 0xFE |
  | 0x11 | 0xFC |
  | 0x1A | 0x01 |
  | 0x1B | 0x01 |
  | 0x31 | 0x0F |
  | 0x32 | 0x0F |

  Masked-out bits read as zero.
- R3: Reserved bytes ignore writes and read as zero. They are 0x02, 0x04, 0x06, 0x08, 0x0C, 0x14–0x19, 0x1C–0x1F, 0x30 and 0x3A–0x3F.
- R4: The data ports are word addresses 0x12, 0x34, 0x36 and 0x38, with `port_id` 0, 1, 2 and 3 in that order.
  - An 8-bit even write only latches its byte.
  - An 8-bit odd write raises `port_valid` for the cycle after the write, with `port_data = {latch, new byte}`. It then clears that port's latch.
  - Each port has its own latch.
  - Port bytes read as zero.
- R5: A 16-bit write to a data port raises `port_valid` in the cycle after the write, with `port_data = wr_data`.
- R6: `sub_reset` pulses for one cycle after a write that changes byte 0x01 bit 1 from 0 to 1. Any other write to that byte gives no pulse.
- R7: The bank field is byte 0x05 bits 1:0 and is output on `bank_sel`. `bank_change` pulses for one cycle after a write that changes the field, and stays low otherwise.
- R8: `irq_update` pulses for one cycle after a write that changes the interrupt field, byte 0x03 bits 1:0.
- R9: Mailboxes occupy 0x20–0x2F. A mailbox write whose written bytes all equal the stored bytes is ignored. Any other mailbox write stores the data and sets `mbox_dirty[(addr & 0xF) >> 1]` in the next cycle.
- R10: A high `mbox_ack[i]` clears `mbox_dirty[i]` on the next edge. A set in the same cycle wins over the acknowledge.
- R11: After reset every byte reads zero, and `bank_sel`, `mbox_dirty` and all strobes are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request this cycle |
| wr_word | input | 1 | 1 = 16-bit write, 0 = 8-bit write |
| wr_addr | input | 6 | Byte address |
| wr_data | input | 16 | Write data (8-bit writes use bits 7:0) |
| rd_addr | input | 6 | Read byte address |
| rd_data | output | 16 | Aligned word at rd_addr, even byte high |
| mbox_ack | input | 8 | Per-mailbox dirty clear |
| mbox_dirty | output | 8 | Per-mailbox dirty flags |
| port_valid | output | 1 | Downstream word valid, one cycle |
| port_id | output | 2 | Which data port produced the word |
| port_data | output | 16 | Downstream word |
| sub_reset | output | 1 | Reset pulse for attached processors |
| bank_sel | output | 2 | Current bank field |
| bank_change | output | 1 | Bank field changed |
| irq_update | output | 1 | Interrupt field changed |

## Verification
Faults in stored state show up directly on `rd_data`. A wrong mask or a wrongly decoded reserved byte shows on the first read after the write, with no added latency.

A stale data-port latch is only visible on the next odd write to that port. There it appears as a wrong high byte in `port_data`. The bench therefore interleaves ports and repeats odd writes.

Edge-detector faults in the reset, bank and interrupt logic show one cycle after the write. They appear as a missing or spurious pulse. Each is probed with both changing and repeated writes. Mailbox compare errors show as a dirty bit that does or does not rise one cycle after the write.

// File: rtl/ctl_regfile.sv
module ctl_regfile #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int NMB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_word,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [NMB-1:0] mbox_ack,
  output logic [NMB-1:0] mbox_dirty,
  output logic          port_valid,
  output logic [1:0]    port_id,
  output logic [DW-1:0] port_data,
  output logic          sub_reset,
  output logic [1:0]    bank_sel,
  output logic          bank_change,
  output logic          irq_update
);
  localparam int NB = 1 << AW;
  localparam int BW = DW / 2;

  logic [BW-1:0] regs [NB];
  logic [BW-1:0] latch [4];

  function automatic logic [BW-1:0] wmask(input logic [AW-1:0] a);
    case (a)
      6'h00: wmask = 8'h80;
      6'h01, 6'h03, 6'h05: wmask = 8'h03;
      6'h07: wmask = 8'h07;
      6'h09, 6'h0A, 6'h0D, 6'h0E, 6'h0F, 6'h10, 6'h33: wmask = 8'hFF;
      6'h0B: wmask = 8'hFE;
      6'h11: wmask = 8'hFC;
      6'h1A, 6'h1B: wmask = 8'h01;
      6'h31, 6'h32: wmask = 8'h0F;
      default: wmask = (a[5:4] == 2'b10) ? 8'hFF : 8'h00;
    endcase
  endfunction

  logic [AW-1:0] ae, ao;
  logic [BW-1:0] hi_d, lo_d;
  logic hi_we, lo_we, is_mb, mb_same, commit, stg;
  logic [1:0] sidx;
  logic [NMB-1:0] dirty_set;

  assign ae = {wr_addr[AW-1:1], 1'b0};
  assign ao = {wr_addr[AW-1:1], 1'b1};
  assign hi_d = wr_word ? wr_data[DW-1:BW] : wr_data[BW-1:0];
  assign lo_d = wr_data[BW-1:0];
  assign hi_we = wr_en && (wr_word || !wr_addr[0]);
  assign lo_we = wr_en && (wr_word || wr_addr[0]);
  assign is_mb = (ae[5:4] == 2'b10);
  assign mb_same = (!hi_we || regs[ae] == hi_d) && (!lo_we || regs[ao] == lo_d);
  assign commit = !is_mb || !mb_same;
  assign dirty_set = (wr_en && is_mb && !mb_same) ? (NMB'(1) << ae[3:1]) : '0;

  always_comb begin
    stg = 1'b1;
    case (ae)
      6'h12: sidx = 2'd0;
      6'h34: sidx = 2'd1;
      6'h36: sidx = 2'd2;
      6'h38: sidx = 2'd3;
      default: begin sidx = 2'd0; stg = 1'b0; end
    endcase
  end

  logic ctl_run;
  logic [1:0] irq_field;
  assign ctl_run = regs[1][1];
  assign irq_field = regs[3][1:0];
  assign bank_sel = regs[5][1:0];
  assign rd_data = {regs[{rd_addr[AW-1:1], 1'b0}], regs[{rd_addr[AW-1:1], 1'b1}]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) regs[i] <= '0;
      for (int i = 0; i < 4; i++) latch[i] <= '0;
      mbox_dirty  <= '0;
      port_valid  <= 1'b0;
      port_id     <= '0;
      port_data   <= '0;
      sub_reset   <= 1'b0;
      bank_change <= 1'b0;
      irq_update  <= 1'b0;
    end else begin
      sub_reset   <= lo_we && ae == 6'h00 && lo_d[1] && !ctl_run;
      bank_change <= lo_we && ae == 6'h04 && lo_d[1:0] != bank_sel;
      irq_update  <= lo_we && ae == 6'h02 && lo_d[1:0] != irq_field;
      if (hi_we && commit) regs[ae] <= hi_d & wmask(ae);
      if (lo_we && commit) regs[ao] <= lo_d & wmask(ao);
      port_valid <= stg && lo_we;
      if (stg && lo_we) begin
        port_id   <= sidx;
        port_data <= wr_word ? wr_data : {latch[sidx], lo_d};
      end
      if (stg && wr_en) latch[sidx] <= (hi_we && !lo_we) ? hi_d : '0;
      mbox_dirty <= (mbox_dirty & ~mbox_ack) | dirty_set;
    end
  end

  p_port_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    port_valid |-> $past(wr_en));
  p_reset_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sub_reset |-> (ctl_run && !$past(ctl_run)));
  p_bank_moved_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bank_change |-> (bank_sel != $past(bank_sel)));
  p_irq_moved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_update |-> (irq_field != $past(irq_field)));
  p_dirty_from_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(mbox_dirty & ~$past(mbox_dirty))) |-> $past(wr_en));
  p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_ack != '0 && !wr_en) |=> ((mbox_dirty & $past(mbox_ack)) == '0));
endmodule

// File: tb/tb_ctl_regfile.sv
module tb_ctl_regfile;
  logic clk = 0, rst_n = 0, wr_en = 0, wr_word = 0;
  logic [5:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [7:0] mbox_ack = 0;
  logic [15:0] rd_data, port_data;
  logic [7:0] mbox_dirty;
  logic port_valid, sub_reset, bank_change, irq_update;
  logic [1:0] port_id, bank_sel;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ctl_regfile dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .mbox_ack(mbox_ack), .mbox_dirty(mbox_dirty), .port_valid(port_valid),
    .port_id(port_id), .port_data(port_data), .sub_reset(sub_reset),
    .bank_sel(bank_sel), .bank_change(bank_change), .irq_update(irq_update));

  // {word, wr_addr, wr_data, rd_addr, expected rd_data}
  localparam int NV = 12;
  localparam logic [44:0] VEC [NV] = '{
    {1'b1, 6'h08, 16'hABCD, 6'h08, 16'h00CD},  // R3 R1
    {1'b0, 6'h0B, 16'h00FF, 6'h0A, 16'h00FE},  // R2
    {1'b0, 6'h11, 16'h00FF, 6'h10, 16'h00FC},  // R2
    {1'b1, 6'h10, 16'h1237, 6'h11, 16'h1234},  // R2 R1
    {1'b0, 6'h1B, 16'h00FF, 6'h1A, 16'h0001},  // R2
    {1'b1, 6'h1A, 16'hFFFF, 6'h1A, 16'h0101},  // R2
    {1'b0, 6'h31, 16'h00FF, 6'h30, 16'h000F},  // R2
    {1'b1, 6'h32, 16'hFFFF, 6'h32, 16'h0FFF},  // R2
    {1'b0, 6'h3B, 16'h0055, 6'h3A, 16'h0000},  // R3
    {1'b1, 6'h0D, 16'h5A5A, 6'h0C, 16'h005A},  // R1 R3
    {1'b0, 6'h00, 16'h00FF, 6'h00, 16'h8000},  // R2
    {1'b0, 6'h17, 16'h00AA, 6'h16, 16'h0000}   // R3
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic w, input logic [5:0] a, input logic [15:0] d, input logic [7:0] ack = 0);
    @(negedge clk);
    wr_en = 1; wr_word = w; wr_addr = a; wr_data = d; mbox_ack = ack;
    @(negedge clk);
    wr_en = 0; mbox_ack = 0;
  endtask

  task automatic rd(input logic [5:0] a, input string req, input logic [15:0] exp);
    rd_addr = a; #1; check(req, rd_data, exp);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    rd(6'h00, "R11", 16'h0);
    rd(6'h20, "R11", 16'h0);
    rd(6'h32, "R11", 16'h0);
    check("R11", {6'b0, bank_sel, mbox_dirty}, 16'h0);
    check("R11", {13'b0, sub_reset, bank_change, irq_update}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][44], VEC[i][43:38], VEC[i][37:22]);
      rd(VEC[i][21:16], "R1/R2/R3 table", VEC[i][15:0]);
    end

    // R6 reset pulse on rising bit 1 of byte 0x01
    wr(0, 6'h01, 16'h0002); check("R6", sub_reset, 1);
    @(negedge clk); check("R6", sub_reset, 0);
    wr(0, 6'h01, 16'h0003); check("R6", sub_reset, 0);
    rd(6'h00, "R6", 16'h8003);
    wr(1, 6'h00, 16'h0000); check("R6", sub_reset, 0);
    wr(1, 6'h00, 16'h0002); check("R6", sub_reset, 1);

    // R7 bank
    wr(0, 6'h05, 16'h0007); check("R7", bank_change, 1); check("R7", bank_sel, 3);
    wr(0, 6'h05, 16'h0003); check("R7", bank_change, 0);
    wr(1, 6'h04, 16'hFF01); check("R7", bank_change, 1); check("R7", bank_sel, 1);
    rd(6'h04, "R7", 16'h0001);

    // R8 interrupt field
    wr(0, 6'h03, 16'h0002); check("R8", irq_update, 1);
    wr(0, 6'h03, 16'h0002); check("R8", irq_update, 0);
    rd(6'h02, "R8", 16'h0002);

    // R4 staged ports
    wr(0, 6'h12, 16'h00AB); check("R4", port_valid, 0);
    wr(0, 6'h13, 16'h00CD);
    check("R4", port_valid, 1); check("R4", port_id, 0); check("R4", port_data, 16'hABCD);
    @(negedge clk); check("R4", port_valid, 0);
    wr(0, 6'h13, 16'h0011); check("R4", port_data, 16'h0011);
    wr(0, 6'h34, 16'h0011);
    wr(0, 6'h38, 16'h0022);
    wr(0, 6'h39, 16'h0033); check("R4", port_id, 3); check("R4", port_data, 16'h2233);
    wr(0, 6'h35, 16'h0044); check("R4", port_id, 1); check("R4", port_data, 16'h1144);
    rd(6'h12, "R4", 16'h0); rd(6'h38, "R4", 16'h0);

    // R5 word write to a port
    wr(1, 6'h36, 16'hBEEF);
    check("R5", port_valid, 1); check("R5", port_id, 2); check("R5", port_data, 16'hBEEF);

    // R9 mailboxes
    wr(1, 6'h20, 16'h1234); check("R9", mbox_dirty, 8'h01); rd(6'h20, "R9", 16'h1234);
    wr(1, 6'h00, 16'h0002, 8'h01); check("R10", mbox_dirty, 8'h00);
    wr(1, 6'h20, 16'h1234); check("R9", mbox_dirty, 8'h00);
    wr(0, 6'h21, 16'h0034); check("R9", mbox_dirty, 8'h00);
    wr(0, 6'h2F, 16'h0099); check("R9", mbox_dirty, 8'h80); rd(6'h2E, "R9", 16'h0099);
    wr(0, 6'h2F, 16'h0099, 8'h80); check("R10", mbox_dirty, 8'h00);

    // R10 set wins over acknowledge
    wr(1, 6'h22, 16'h5555, 8'h02); check("R10", mbox_dirty, 8'h02);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule